// File: doc/BRIEF.md
# Hysteresis Pump Command Controller

This block holds a tank level inside a band by switching a feed pump with hysteresis. Each valid level sample is one control step. The block keeps a single pump state bit and compares the sample against a low and a high threshold. It issues a command only on a step where the pump must change state. The command is a strobe with one value bit, so between changes the command stream is silent.

A hold stage rebuilds a steady pump-enable level from the most recent command and drives the actuator. The first valid sample after reset always produces an explicit "off" command. From then on the hold output always matches the controller's pump state, one cycle late.

Top module: `hyst_pump_ctrl`

## Requirements
- R1: During reset and after it is released, before any valid sample, `cmd_vld` is 0 and `pump_en` is 0.
- R2: On the first valid sample after reset, the block sends an off command (`cmd_vld`=1, `cmd_on`=0) whatever the level is, and the pump state is off.
- R3: With the previous state off and a level above LO_TH (default 300), no command is sent and the state stays off.
- R4: With the previous state off and a level at or below LO_TH, an on command (`cmd_vld`=1, `cmd_on`=1) is sent and the state becomes on.
- R5: With the previous state on and a level below HI_TH (default 700), no command is sent and the state stays on.
- R6: With the previous state on and a level at or above HI_TH, an off command is sent and the state becomes off.
- R7: A cycle with `lvl_vld`=0 sends no command and leaves the pump state unchanged, whatever `lvl` holds.
- R8: Command encoding: `cmd_vld`=1 marks a message and `cmd_on` gives its value (1 = on, 0 = off). The command appears in the cycle after the sampling edge and lasts one cycle per sample. A message is sent exactly when the state changes, apart from the forced first off command.
- R9: `pump_en` loads `cmd_on` on the clock edge after a cycle with `cmd_vld`=1, and holds its value otherwise.
- R10: In a closed loop with a plant that starts at 500 and moves by 1 to 10 per step (down while `pump_en` is 0, up while it is 1), the level stays within 200 to 800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_vld | input | 1 | Level sample valid; one control step per valid cycle |
| lvl | input | LVL_W | Unsigned level sample |
| cmd_vld | output | 1 | Command strobe: a message is present |
| cmd_on | output | 1 | Command value: 1 pump on, 0 pump off |
| pump_en | output | 1 | Held actuator enable, from the last command |

## Verification
The assertions check the following on every cycle:
- idle cycles never change the state or raise a command;
- every state change carries a command of matching value;
- the forced first command is off;
- the hold register follows only commands.

Some behaviour only the bench's scenarios can show: exact threshold boundaries at 300/301 and 699/700, the closed-loop band of 200 to 800 against a moving plant, and the agreement between a bench reference model and long random sequences with idle gaps.

// File: rtl/hyst_pump_pkg.sv
package hyst_pump_pkg;
  typedef struct packed {
    logic vld;
    logic on;
  } pump_cmd_t;

  localparam logic PUMP_OFF = 1'b0;
  localparam logic PUMP_ON  = 1'b1;
  localparam pump_cmd_t CMD_NONE = '{vld: 1'b0, on: 1'b0};
endpackage

// File: rtl/hyst_pump_cmp.sv
module hyst_pump_cmp #(
  parameter int LVL_W = 10,
  parameter int LO_TH = 300,
  parameter int HI_TH = 700
) (
  input  logic [LVL_W-1:0] lvl,
  output logic             low_hit,
  output logic             high_hit
);
  localparam logic [LVL_W-1:0] LO_V = LO_TH[LVL_W-1:0];
  localparam logic [LVL_W-1:0] HI_V = HI_TH[LVL_W-1:0];

  always_comb begin
    low_hit  = (lvl <= LO_V);
    high_hit = (lvl >= HI_V);
  end
endmodule

// File: rtl/hyst_pump_decide.sv
module hyst_pump_decide
  import hyst_pump_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_vld,
  input  logic      low_hit,
  input  logic      high_hit,
  output pump_cmd_t cmd,
  output logic      state
);
  logic      state_q, state_d;
  logic      first_q, first_d;
  pump_cmd_t cmd_q, cmd_d;

  always_comb begin
    state_d = state_q;
    first_d = first_q;
    cmd_d   = CMD_NONE;
    if (smp_vld) begin
      if (first_q) begin
        first_d = 1'b0;
        state_d = PUMP_OFF;
        cmd_d   = '{vld: 1'b1, on: PUMP_OFF};
      end else if (state_q == PUMP_OFF) begin
        if (low_hit) begin
          state_d = PUMP_ON;
          cmd_d   = '{vld: 1'b1, on: PUMP_ON};
        end
      end else if (high_hit) begin
        state_d = PUMP_OFF;
        cmd_d   = '{vld: 1'b1, on: PUMP_OFF};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PUMP_OFF;
      first_q <= 1'b1;
      cmd_q   <= CMD_NONE;
    end else begin
      cmd_q <= cmd_d;
      if (smp_vld) begin
        state_q <= state_d;
        first_q <= first_d;
      end
    end
  end

  assign cmd   = cmd_q;
  assign state = state_q;

  // R2: the forced first command is off
  a_r2_first_off: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && first_q) |=> (cmd_q.vld && cmd_q.on == PUMP_OFF && state_q == PUMP_OFF));
  // R7: idle cycles change nothing
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(state_q) && !cmd_q.vld));
  // R8: every state change is announced with a matching value
  a_r8_change_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> (cmd_q.vld && cmd_q.on == state_q));
  // R8: a command value always agrees with the new state
  a_r8_cmd_matches: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.vld |-> (cmd_q.on == state_q));
  // R3: off state with a high level stays off
  a_r3_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !first_q && state_q == PUMP_OFF && !low_hit) |=> (state_q == PUMP_OFF && !cmd_q.vld));
  // R5: on state with a level below the high mark stays on
  a_r5_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !first_q && state_q == PUMP_ON && !high_hit) |=> (state_q == PUMP_ON && !cmd_q.vld));
endmodule

// File: rtl/hyst_pump_hold.sv
module hyst_pump_hold
  import hyst_pump_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pump_cmd_t cmd,
  output logic      pump_en
);
  logic en_q, en_d;

  always_comb begin
    en_d = cmd.on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= PUMP_OFF;
    end else if (cmd.vld) begin
      en_q <= en_d;
    end
  end

  assign pump_en = en_q;

  // R9: a command is taken on the next edge
  a_r9_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.vld |=> (en_q == $past(cmd.on)));
  // R9: without a command the output holds
  a_r9_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.vld |=> $stable(en_q));
endmodule

// File: rtl/hyst_pump_ctrl.sv
module hyst_pump_ctrl
  import hyst_pump_pkg::*;
#(
  parameter int LVL_W = 10,
  parameter int LO_TH = 300,
  parameter int HI_TH = 700,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_vld,
  input  logic [LVL_W-1:0] lvl,
  output logic             cmd_vld,
  output logic             cmd_on,
  output logic             pump_en
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic                   low_hit, high_hit, state;
  pump_cmd_t              cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  hyst_pump_cmp #(.LVL_W(LVL_W), .LO_TH(LO_TH), .HI_TH(HI_TH)) i_cmp (
    .lvl      (lvl),
    .low_hit  (low_hit),
    .high_hit (high_hit)
  );

  hyst_pump_decide i_decide (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .smp_vld  (lvl_vld),
    .low_hit  (low_hit),
    .high_hit (high_hit),
    .cmd      (cmd),
    .state    (state)
  );

  hyst_pump_hold i_hold (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cmd     (cmd),
    .pump_en (pump_en)
  );

  assign cmd_vld = cmd.vld;
  assign cmd_on  = cmd.on;

  // R1: nothing is sent while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n_int |-> (!cmd_vld && !pump_en));
  // R9: after a command the actuator follows the controller state
  a_r9_en_tracks: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_vld |=> (pump_en == $past(state)));
endmodule

// File: tb/test_hyst_pump_ctrl.sv
module test_hyst_pump_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lvl_vld = 1'b0;
  logic [9:0] lvl = '0;
  logic       cmd_vld, cmd_on, pump_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit m_first = 1;
  bit m_state = 0;

  always #10 clk = ~clk;

  hyst_pump_ctrl i_hyst_pump_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl_vld(lvl_vld), .lvl(lvl),
    .cmd_vld(cmd_vld), .cmd_on(cmd_on), .pump_en(pump_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: returns {vld, on}
  function automatic logic [1:0] model_step(input int l);
    logic [1:0] r;
    r = 2'b00;
    if (m_first) begin
      m_first = 0; m_state = 0; r = 2'b10;
    end else if (!m_state) begin
      if (l <= 300) begin m_state = 1; r = 2'b11; end
    end else if (l >= 700) begin
      m_state = 0; r = 2'b10;
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; lvl_vld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_first = 1; m_state = 0;
    chk(cmd_vld == 0, "R1 cmd_vld", cmd_vld, 0);
    chk(pump_en == 0, "R1 pump_en", pump_en, 0);
  endtask

  // one sample; checks command and held output against the model
  task automatic step(input int l, input string req);
    logic [1:0] e;
    @(negedge clk); lvl_vld = 1; lvl = l[9:0];
    @(negedge clk); lvl_vld = 0;
    e = model_step(l);
    chk(cmd_vld == e[1], {req, " cmd_vld"}, cmd_vld, e[1]);
    if (e[1]) chk(cmd_on == e[0], {req, " cmd_on"}, cmd_on, e[0]);
    @(negedge clk);
    chk(cmd_vld == 0, "R8 single pulse", cmd_vld, 0);
    chk(pump_en == m_state, "R9 pump_en", pump_en, m_state);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int plant;
    void'($urandom(32'd1234));
    do_reset();
    step(0, "R2 first off at low level");
    step(301, "R3 off above low mark");
    step(300, "R4 on at low mark");
    step(699, "R5 on below high mark");
    step(700, "R6 off at high mark");
    step(301, "R3 off boundary 301");
    step(150, "R4 on low level");
    // R7: lvl changes while lvl_vld low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); lvl = (i % 2) ? 10'd1000 : 10'd0;
      chk(cmd_vld == 0, "R7 idle cmd_vld", cmd_vld, 0);
      chk(pump_en == 1, "R7 idle pump_en", pump_en, 1);
    end
    step(500, "R5 still on after idle");
    step(1023, "R6 off at max level");
    do_reset();
    step(900, "R2 first off at high level");
    // random levels with idle gaps
    for (int i = 0; i < 400; i++) begin
      int l;
      l = ($urandom % 2) ? int'($urandom_range(250, 750)) : int'($urandom_range(0, 1023));
      repeat ($urandom_range(0, 3)) @(negedge clk);
      step(l, "R8 random");
    end
    // closed loop plant
    do_reset();
    plant = 500;
    for (int i = 0; i < 600; i++) begin
      int d;
      step(plant, "R10 loop");
      d = int'($urandom_range(1, 10));
      plant = pump_en ? plant + d : plant - d;
      chk(plant >= 200 && plant <= 800, "R10 band", plant, 500);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule